// File: doc/BRIEF.md
# Processor Status Word and Exception Entry Unit

This block owns the 32-bit processor status word of a small core. The word carries the four condition flags at the top, two interrupt mask bits, an instruction-set state bit and a 5-bit mode field. Instructions that set flags drive the ALU result, carry and overflow together with a flag-write enable. Move-to-status instructions drive a write port. What a write may change depends on the mode the core is in.

Exception requests arrive as level inputs. Interrupts are gated by their mask bits in the current word. A request is acted on only in a cycle where the execute stage reports that its instruction has finished. On entry the unit saves the word as the finishing instruction left it. It then switches mode, raises the masks, clears the state bit, pulses a take strobe and presents the vector-table address for the fetch unit.

Top module: `status_word_unit`

## Requirements
- R1: After a synchronous active-low reset the status word is 0x000000D3 (supervisor mode 10011, bits 7 and 6 set, bit 5 clear). The saved word, the take strobe and the vector are all zero.
- R2: When the flag-write enable is high and no status write is present, four bits are updated: bit 31 takes bit 31 of the ALU result, bit 30 is set exactly when the result is zero, bit 29 takes the carry input and bit 28 takes the overflow input. Bits 27:0 are unchanged.
- R3: A status write made while the mode is not user (10000) replaces the whole word. It takes priority over a flag update in the same cycle.
- R4: The legal mode encodings are user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. A privileged write whose bits 4:0 hold another value writes bits 31:5 and leaves the mode unchanged.
- R5: A status write made in user mode changes only bits 31:28.
- R6: An IRQ request is ignored while bit 7 of the word is 1, and an FIQ request is ignored while bit 6 is 1. The mask values used are those of the word at the start of the cycle. Abort and undefined requests cannot be masked.
- R7: An exception is entered only in a cycle with the execute-done input high. Requests in other cycles are not remembered.
- R8: When several requests are accepted in the same cycle, abort wins over FIQ, FIQ over IRQ, and IRQ over undefined.
- R9: On entry the saved word receives the status word including that cycle's flag or status write. The new word keeps bits 31:8, sets bits 4:0 to the exception's mode, sets bit 7 and clears bit 5. Only FIQ entry also sets bit 6.
- R10: The take output is high for exactly the cycle after each entry edge. The vector output then shows 0x04 for undefined, 0x10 for abort, 0x18 for IRQ or 0x1C for FIQ, and holds that value until the next entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_result | input | 32 | Result of the flag-setting instruction |
| alu_carry | input | 1 | Unsigned carry out of the ALU |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| flag_we | input | 1 | Update condition flags from the ALU |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Status word write data |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| abort_req | input | 1 | Memory abort request |
| undef_req | input | 1 | Undefined instruction request |
| exec_done | input | 1 | Instruction in execute stage has finished |
| psw | output | 32 | Current status word |
| cur_mode | output | 5 | Current mode field |
| exc_take | output | 1 | Exception entered on the previous edge |
| exc_vector | output | 32 | Vector-table address of the last exception |
| saved_psw | output | 32 | Word saved at the last exception entry |

## Verification
Several properties are checked on every cycle. A take strobe must follow a cycle with execute-done high. An IRQ or FIQ taken must have had its mask clear. Every entry must leave the IRQ mask set and the state bit clear. An accepted abort must always win. User mode must leave bits 27:0 untouched. The mode field must always hold a legal encoding, and the vector must stay steady between entries. Other behaviour can only be shown by the bench's scenarios against a reference model: the exact flag values, the priority order among lower-ranked requests, the saved word including the same-cycle update, and the reset word.

// File: rtl/sw_pkg.sv
// Package: shared constants, mode and exception encodings for the status word unit.
// Assumes a 32-bit status word with fixed field positions.
package sw_pkg;
    localparam int SW_W   = 32;
    localparam int N_BIT  = 31;
    localparam int Z_BIT  = 30;
    localparam int C_BIT  = 29;
    localparam int V_BIT  = 28;
    localparam int I_BIT  = 7;
    localparam int F_BIT  = 6;
    localparam int T_BIT  = 5;
    localparam int MODE_W = 5;

    localparam logic [SW_W-1:0] RESET_WORD = 32'h0000_00D3;

    localparam int VEC_UND = 'h04;
    localparam int VEC_ABT = 'h10;
    localparam int VEC_IRQ = 'h18;
    localparam int VEC_FIQ = 'h1C;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        EXC_NONE,
        EXC_UND,
        EXC_IRQ,
        EXC_FIQ,
        EXC_ABT
    } exc_e;

    // True for the seven legal mode encodings.
    function automatic logic mode_ok(input logic [MODE_W-1:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: mode_ok = 1'b1;
            default:                      mode_ok = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/sw_next_word.sv
// Module: computes the status word after this cycle's flag update or status write.
// Assumes the write port wins over the flag update; the user mode write
// reaches the flag nibble only; an illegal mode in a privileged write keeps the mode.
module sw_next_word
    import sw_pkg::*;
(
    input  logic [SW_W-1:0] cur_word,
    input  logic [SW_W-1:0] alu_result,
    input  logic            alu_carry,
    input  logic            alu_ovf,
    input  logic            flag_we,
    input  logic            wr_en,
    input  logic [SW_W-1:0] wr_data,
    output logic [SW_W-1:0] next_word
);
    localparam int FLAG_LSB = V_BIT;

    logic in_user;
    assign in_user = (cur_word[MODE_W-1:0] == MODE_USR);

    // Purpose: merge the write port or the ALU flags into the current word.
    always_comb begin
        next_word = cur_word;
        if (wr_en) begin
            if (in_user) begin
                next_word[SW_W-1:FLAG_LSB] = wr_data[SW_W-1:FLAG_LSB];
            end else begin
                next_word[SW_W-1:MODE_W] = wr_data[SW_W-1:MODE_W];
                if (mode_ok(wr_data[MODE_W-1:0])) begin
                    next_word[MODE_W-1:0] = wr_data[MODE_W-1:0];
                end
            end
        end else if (flag_we) begin
            next_word[N_BIT] = alu_result[SW_W-1];
            next_word[Z_BIT] = ~|alu_result;
            next_word[C_BIT] = alu_carry;
            next_word[V_BIT] = alu_ovf;
        end
    end
endmodule

// File: rtl/sw_exc_arb.sv
// Module: masks interrupts and picks the exception to enter this cycle.
// Assumes requests are levels sampled only when execute_done is high;
// priority abort > FIQ > IRQ > undefined.
module sw_exc_arb
    import sw_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic              irq_mask,
    input  logic              fiq_mask,
    input  logic              exec_done,
    input  logic              abort_req,
    input  logic              fiq_req,
    input  logic              irq_req,
    input  logic              undef_req,
    output exc_e              kind,
    output logic [MODE_W-1:0] enter_mode,
    output logic [VEC_W-1:0]  vector
);
    logic fiq_live;
    logic irq_live;
    assign fiq_live = fiq_req & ~fiq_mask;
    assign irq_live = irq_req & ~irq_mask;

    // Purpose: priority select of the accepted request, its mode and vector.
    always_comb begin
        kind       = EXC_NONE;
        enter_mode = MODE_SVC;
        vector     = '0;
        if (exec_done) begin
            if (abort_req) begin
                kind       = EXC_ABT;
                enter_mode = MODE_ABT;
                vector     = VEC_W'(VEC_ABT);
            end else if (fiq_live) begin
                kind       = EXC_FIQ;
                enter_mode = MODE_FIQ;
                vector     = VEC_W'(VEC_FIQ);
            end else if (irq_live) begin
                kind       = EXC_IRQ;
                enter_mode = MODE_IRQ;
                vector     = VEC_W'(VEC_IRQ);
            end else if (undef_req) begin
                kind       = EXC_UND;
                enter_mode = MODE_UND;
                vector     = VEC_W'(VEC_UND);
            end
        end
    end
endmodule

// File: rtl/status_word_unit.sv
// Module: status word register with flag update, mode-dependent writes and
// exception entry. Assumes one request is serviced per execute-done cycle and
// that the fetch unit consumes exc_vector while exc_take is high.
module status_word_unit
    import sw_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW_W-1:0]   alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic              flag_we,
    input  logic              wr_en,
    input  logic [SW_W-1:0]   wr_data,
    input  logic              irq_req,
    input  logic              fiq_req,
    input  logic              abort_req,
    input  logic              undef_req,
    input  logic              exec_done,
    output logic [SW_W-1:0]   psw,
    output logic [MODE_W-1:0] cur_mode,
    output logic              exc_take,
    output logic [VEC_W-1:0]  exc_vector,
    output logic [SW_W-1:0]   saved_psw
);
    logic [SW_W-1:0]   word_q;
    logic [SW_W-1:0]   saved_q;
    logic [VEC_W-1:0]  vec_q;
    logic              take_q;
    logic [SW_W-1:0]   upd_word;
    logic [SW_W-1:0]   entry_word;
    exc_e              kind;
    logic [MODE_W-1:0] enter_mode;
    logic [VEC_W-1:0]  arb_vec;

    sw_next_word u_next (
        .cur_word   (word_q),
        .alu_result (alu_result),
        .alu_carry  (alu_carry),
        .alu_ovf    (alu_ovf),
        .flag_we    (flag_we),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .next_word  (upd_word)
    );

    sw_exc_arb #(.VEC_W(VEC_W)) u_arb (
        .irq_mask   (word_q[I_BIT]),
        .fiq_mask   (word_q[F_BIT]),
        .exec_done  (exec_done),
        .abort_req  (abort_req),
        .fiq_req    (fiq_req),
        .irq_req    (irq_req),
        .undef_req  (undef_req),
        .kind       (kind),
        .enter_mode (enter_mode),
        .vector     (arb_vec)
    );

    // Purpose: build the word seen after an exception entry.
    always_comb begin
        entry_word                = upd_word;
        entry_word[MODE_W-1:0]    = enter_mode;
        entry_word[I_BIT]         = 1'b1;
        entry_word[T_BIT]         = 1'b0;
        if (kind == EXC_FIQ) begin
            entry_word[F_BIT] = 1'b1;
        end
    end

    // Purpose: register the status word, saved word, vector and take strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= RESET_WORD;
            saved_q <= '0;
            vec_q   <= '0;
            take_q  <= 1'b0;
        end else begin
            take_q <= (kind != EXC_NONE);
            if (kind != EXC_NONE) begin
                word_q  <= entry_word;
                saved_q <= upd_word;
                vec_q   <= arb_vec;
            end else begin
                word_q  <= upd_word;
            end
        end
    end

    assign psw        = word_q;
    assign cur_mode   = word_q[MODE_W-1:0];
    assign exc_take   = take_q;
    assign exc_vector = vec_q;
    assign saved_psw  = saved_q;

    p_take_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> $past(exec_done));

    p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exc_vector == VEC_W'(VEC_IRQ)) |-> !$past(psw[I_BIT]));

    p_fiq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exc_vector == VEC_W'(VEC_FIQ)) |-> !$past(psw[F_BIT]));

    p_entry_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (psw[I_BIT] && !psw[T_BIT]));

    p_abort_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_done && abort_req) |=> (exc_take && exc_vector == VEC_W'(VEC_ABT)));

    p_user_ctrl_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_USR && kind == EXC_NONE) |=> (psw[V_BIT-1:0] == $past(psw[V_BIT-1:0])));

    p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(cur_mode));

    p_vector_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take |-> $stable(exc_vector));
endmodule

// File: tb/status_word_unit_tb_top.sv
`timescale 1ns/1ps
module status_word_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] alu_result = '0;
    logic        alu_carry = 1'b0, alu_ovf = 1'b0, flag_we = 1'b0, wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        irq_req = 1'b0, fiq_req = 1'b0, abort_req = 1'b0, undef_req = 1'b0, exec_done = 1'b0;
    logic [31:0] psw, saved_psw, exc_vector;
    logic [4:0]  cur_mode;
    logic        exc_take;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_psw, m_saved, m_vec;
    logic        m_take;

    always #2.5 clk = ~clk;

    status_word_unit dut_i (
        .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
        .alu_ovf(alu_ovf), .flag_we(flag_we), .wr_en(wr_en), .wr_data(wr_data),
        .irq_req(irq_req), .fiq_req(fiq_req), .abort_req(abort_req), .undef_req(undef_req),
        .exec_done(exec_done), .psw(psw), .cur_mode(cur_mode), .exc_take(exc_take),
        .exc_vector(exc_vector), .saved_psw(saved_psw)
    );

    function automatic logic legal(input logic [4:0] m);
        return m == 5'b10000 || m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
               m == 5'b10111 || m == 5'b11011 || m == 5'b11111;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: next state from the requirements, given the current inputs.
    task automatic model_step(output logic [31:0] np, output logic [31:0] ns,
                              output logic [31:0] nv, output logic nt);
        logic [31:0] w;
        int kind;
        w = m_psw;
        if (wr_en) begin
            if (m_psw[4:0] == 5'b10000) w[31:28] = wr_data[31:28];
            else begin
                w[31:5] = wr_data[31:5];
                if (legal(wr_data[4:0])) w[4:0] = wr_data[4:0];
            end
        end else if (flag_we) begin
            w[31] = alu_result[31];
            w[30] = (alu_result == 0);
            w[29] = alu_carry;
            w[28] = alu_ovf;
        end
        kind = 0;
        if (exec_done) begin
            if (abort_req)                   kind = 1;
            else if (fiq_req && !m_psw[6])   kind = 2;
            else if (irq_req && !m_psw[7])   kind = 3;
            else if (undef_req)              kind = 4;
        end
        ns = m_saved; nv = m_vec; nt = (kind != 0); np = w;
        if (kind != 0) begin
            ns = w;
            np[7] = 1'b1;
            np[5] = 1'b0;
            case (kind)
                1: begin np[4:0] = 5'b10111; nv = 32'h10; end
                2: begin np[4:0] = 5'b10001; nv = 32'h1C; np[6] = 1'b1; end
                3: begin np[4:0] = 5'b10010; nv = 32'h18; end
                default: begin np[4:0] = 5'b11011; nv = 32'h04; end
            endcase
        end
    endtask

    // Drive one cycle of inputs, then compare every output to the model.
    task automatic step(input string tag, input logic [31:0] res, input logic c, input logic v,
                        input logic fw, input logic we, input logic [31:0] wd,
                        input logic irq, input logic fiq, input logic abt,
                        input logic und, input logic done);
        logic [31:0] np, ns, nv;
        logic nt;
        alu_result = res; alu_carry = c; alu_ovf = v; flag_we = fw; wr_en = we; wr_data = wd;
        irq_req = irq; fiq_req = fiq; abort_req = abt; undef_req = und; exec_done = done;
        model_step(np, ns, nv, nt);
        @(negedge clk);
        m_psw = np; m_saved = ns; m_vec = nv; m_take = nt;
        check({tag, " psw"}, psw, m_psw);
        check({tag, " saved"}, saved_psw, m_saved);
        check({tag, " vector"}, exc_vector, m_vec);
        check({tag, " take"}, {31'd0, exc_take}, {31'd0, m_take});
    endtask

    task automatic wr(input string tag, input logic [31:0] wd);
        step(tag, 0, 0, 0, 0, 1, wd, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(100000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_psw = 32'h0000_00D3; m_saved = '0; m_vec = '0; m_take = 1'b0;
        // R1: reset values
        check("R1 psw", psw, 32'h0000_00D3);
        check("R1 saved", saved_psw, 32'h0);
        check("R1 vector", exc_vector, 32'h0);
        check("R1 take", {31'd0, exc_take}, 32'h0);
        check("R1 mode", {27'd0, cur_mode}, 32'h13);

        // R2: flag updates
        step("R2 zero", 32'h0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R2 zero flags", {28'd0, psw[31:28]}, 32'h6);
        step("R2 neg", 32'h8000_0001, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R2 neg flags", psw, 32'h9000_00D3);

        // R3: privileged write wins over flag update
        step("R3 write", 32'h0, 1, 1, 1, 1, 32'h0000_001F, 0, 0, 0, 0, 0);
        check("R3 word", psw, 32'h0000_001F);

        // R4: illegal mode keeps mode
        wr("R4 bad mode", 32'hA000_0015);
        check("R4 word", psw, 32'hA000_001F);

        // R6: masked requests ignored
        wr("R6 mask", 32'h0000_00DF);
        step("R6 masked", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1);
        check("R6 no take", {31'd0, exc_take}, 32'h0);
        check("R6 mode kept", {27'd0, cur_mode}, 32'h1F);

        // R7: request without execute-done ignored, then taken
        wr("R7 unmask", 32'h0000_001F);
        step("R7 not done", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        check("R7 no take", {31'd0, exc_take}, 32'h0);
        step("R7 done", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
        check("R7 take", {31'd0, exc_take}, 32'h1);
        check("R10 irq vector", exc_vector, 32'h18);
        check("R9 irq word", psw, 32'h0000_0092);
        check("R9 irq saved", saved_psw, 32'h0000_001F);
        step("R10 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R10 pulse end", {31'd0, exc_take}, 32'h0);
        check("R10 vector hold", exc_vector, 32'h18);

        // R8: priority order
        wr("R8 prep", 32'h0000_001F);
        step("R8 all", 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1);
        check("R8 abort", exc_vector, 32'h10);
        check("R8 abort word", psw, 32'h0000_0097);
        wr("R8 prep", 32'h0000_001F);
        step("R8 fiq", 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1);
        check("R8 fiq vector", exc_vector, 32'h1C);
        check("R9 fiq word", psw, 32'h0000_00D1);
        wr("R8 prep", 32'h0000_001F);
        step("R8 irq", 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1);
        check("R8 irq vector", exc_vector, 32'h18);
        wr("R8 prep", 32'h0000_001F);
        step("R8 undef", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        check("R8 undef vector", exc_vector, 32'h04);
        check("R9 undef word", psw, 32'h0000_009B);

        // R5: user-mode writes reach only the flags
        wr("R5 to user", 32'h0000_0010);
        wr("R5 user write", 32'hF000_00FF);
        check("R5 word", psw, 32'hF000_0010);
        step("R5 abort from user", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        check("R5 saved", saved_psw, 32'hF000_0010);

        // R9: saved word includes the same-cycle flag update
        wr("R9 prep", 32'h0000_001F);
        step("R9 flag+irq", 32'h0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 1);
        check("R9 saved flags", saved_psw, 32'h4000_001F);
        check("R9 entry word", psw, 32'h4000_0092);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] wd;
            logic [4:0]  md;
            case ($urandom % 8)
                0: md = 5'b10000; 1: md = 5'b10001; 2: md = 5'b10010; 3: md = 5'b10011;
                4: md = 5'b10111; 5: md = 5'b11011; 6: md = 5'b11111; default: md = 5'b00101;
            endcase
            wd = {$urandom} & 32'hFFFF_FFE0;
            wd[4:0] = md;
            step("random", ($urandom % 4 == 0) ? 32'h0 : $urandom, 1'($urandom), 1'($urandom),
                 ($urandom % 2 == 0), ($urandom % 6 == 0), wd,
                 ($urandom % 3 == 0), ($urandom % 4 == 0), ($urandom % 10 == 0),
                 ($urandom % 8 == 0), ($urandom % 2 == 0));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule